// File: doc/BRIEF.md
# Direct-Mapped One-Word-Line Data Cache

This block is a data cache placed between a processor-side port and a word-wide memory port. Each line holds exactly one word together with its tag and a valid flag, and lines are chosen by a fixed slice of the physical address, so each address can live in only one line. The two lowest address bits select a byte within the word. Every access here is a full word, so those two bits play no part in the lookup.

Stores are handled without any lookup. The indexed line is overwritten with the new tag and data and marked valid, and the same word is sent on to memory. Loads compare the stored tag against the address tag. A hit returns data in the cycle after the request is accepted. A miss fetches the word from memory, installs it in the line and hands it to the processor in the same cycle the memory acknowledges. The processor port reports busy from acceptance until the operation completes. The number of lines is set by `IDX_W`. A 14-bit index gives 16K lines (64 KB) with a 16-bit tag, and the default is a small 64-line build.

Top module: `dm_wordcache`

## Requirements
- R1: After reset every line is invalid, so the first load from any address misses. `cpu_ready` is 1, and `mem_req` and `cpu_rvalid` are 0.
- R2: Address bits [1:0] are ignored. The index is bits [IDX_W+1:2] and the tag is bits [ADDR_W-1:IDX_W+2]. `mem_addr` always carries bits [1:0] = 00.
- R3: An accepted store overwrites the indexed line's tag and data and sets its valid flag, whatever the line held before. No tag compare is made.
- R4: In the cycle after an accepted store, `mem_req`=1 and `mem_we`=1, with the aligned store address on `mem_addr` and the store data on `mem_wdata`. These outputs hold steady until the cycle in which `mem_ack`=1.
- R5: A load whose line is valid and whose tag matches raises `cpu_rvalid` with the line's data in the cycle after acceptance, and makes no memory request.
- R6: A load miss spends one lookup cycle and then holds `mem_req`=1 with `mem_we`=0 and the aligned address until `mem_ack`. In the acknowledge cycle, `cpu_rvalid`=1 and `cpu_rdata` equals `mem_rdata`, and the word is installed in the line.
- R7: `cpu_ready` is 0 from the cycle after acceptance until the cycle after completion, and a request is accepted only on a clock edge where `cpu_ready`=1.
- R8: Two addresses with the same index but different tags evict each other. A load of the displaced address misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Cache can accept a request this cycle |
| cpu_rvalid | output | 1 | Load data valid |
| cpu_rdata | output | DATA_W | Load data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
A corrupted tag or a stuck valid flag shows up as the wrong choice between hit and miss. On the cycle after the load is accepted, `cpu_rvalid` appears where a memory request was due, or the reverse. A stale data word is visible on `cpu_rdata` in that same cycle. A bad store shows up one cycle after acceptance on the write-through fields, or at the next load of that line. The reference model tracks each line's contents independently and checks every port on every cycle, so any divergence is caught at the first cycle it reaches a port.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_FILL  = 2'd2,
    ST_WRITE = 2'd3
  } dmc_state_e;

  localparam int unsigned OFS_W = 2;

  // line number taken from a byte address
  function automatic logic [63:0] dmc_index_of(input logic [63:0] addr,
                                               input int unsigned idx_w);
    return (addr >> OFS_W) & ((64'd1 << idx_w) - 64'd1);
  endfunction

  // tag: everything above index and byte offset
  function automatic logic [63:0] dmc_tag_of(input logic [63:0] addr,
                                             input int unsigned idx_w);
    return addr >> (OFS_W + idx_w);
  endfunction

  // word-aligned address for the memory side
  function automatic logic [63:0] dmc_align(input logic [63:0] addr);
    return addr & ~64'd3;
  endfunction

endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned TAG_W  = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_bits;
  logic [LINES-1:0]  line_sel;
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];

  // one-hot decode of the written line
  for (genvar g = 0; g < LINES; g++) begin : g_sel
    assign line_sel[g] = wr_en && (wr_idx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_bits <= '0;
    else        valid_bits <= valid_bits | line_sel;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
  end

  // registered read port: line contents one cycle after rd_en
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_tag   <= '0;
      rd_data  <= '0;
    end else if (rd_en) begin
      rd_valid <= valid_bits[rd_idx];
      rd_tag   <= tag_mem[rd_idx];
      rd_data  <= data_mem[rd_idx];
    end
  end

  AST_LINE_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_bits[$past(wr_idx)]); // R3
  AST_LINE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (data_mem[$past(wr_idx)] == $past(wr_data)) && (tag_mem[$past(wr_idx)] == $past(wr_tag))); // R3

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_req,
  input  logic       cpu_we,
  input  logic       lookup_hit,
  input  logic       mem_ack,
  output dmc_state_e state,
  output logic       accept_rd,
  output logic       accept_wr,
  output logic       fill_done
);

  dmc_state_e state_q, state_d;
  logic       write_done;

  assign state      = state_q;
  assign accept_rd  = (state_q == ST_IDLE) && cpu_req && !cpu_we;
  assign accept_wr  = (state_q == ST_IDLE) && cpu_req && cpu_we;
  assign fill_done  = (state_q == ST_FILL) && mem_ack;
  assign write_done = (state_q == ST_WRITE) && mem_ack;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept_rd) state_d = ST_LOOK;
                else if (accept_wr) state_d = ST_WRITE;
      ST_LOOK:  state_d = lookup_hit ? ST_IDLE : ST_FILL;
      ST_FILL:  if (mem_ack) state_d = ST_IDLE;
      ST_WRITE: if (mem_ack) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  AST_LOOK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOK) |=> (state_q != ST_LOOK)); // R5
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_done || write_done) |=> (state_q == ST_IDLE)); // R7

endmodule

// File: rtl/dm_wordcache.sv
module dm_wordcache
  import dmc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFS_W;

  dmc_state_e        state;
  logic              accept_rd, accept_wr, fill_done;
  logic              lookup_hit, lookup_miss;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;

  logic [IDX_W-1:0]  cpu_idx, req_idx;
  logic [TAG_W-1:0]  cpu_tag, req_tag;

  logic              st_wr_en;
  logic [IDX_W-1:0]  st_wr_idx;
  logic [TAG_W-1:0]  st_wr_tag;
  logic [DATA_W-1:0] st_wr_data;
  logic              st_rd_valid;
  logic [TAG_W-1:0]  st_rd_tag;
  logic [DATA_W-1:0] st_rd_data;

  assign cpu_idx = IDX_W'(dmc_index_of(64'(cpu_addr), IDX_W));
  assign cpu_tag = TAG_W'(dmc_tag_of(64'(cpu_addr), IDX_W));
  assign req_idx = IDX_W'(dmc_index_of(64'(req_addr_q), IDX_W));
  assign req_tag = TAG_W'(dmc_tag_of(64'(req_addr_q), IDX_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_addr_q  <= '0;
      req_wdata_q <= '0;
    end else if (accept_rd || accept_wr) begin
      req_addr_q  <= cpu_addr;
      req_wdata_q <= cpu_wdata;
    end
  end

  dmc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .lookup_hit (lookup_hit),
    .mem_ack    (mem_ack),
    .state      (state),
    .accept_rd  (accept_rd),
    .accept_wr  (accept_wr),
    .fill_done  (fill_done)
  );

  // stores write the line at acceptance; fills write it at acknowledge
  assign st_wr_en   = accept_wr || fill_done;
  assign st_wr_idx  = accept_wr ? cpu_idx   : req_idx;
  assign st_wr_tag  = accept_wr ? cpu_tag   : req_tag;
  assign st_wr_data = accept_wr ? cpu_wdata : mem_rdata;

  dmc_line_store #(
    .IDX_W  (IDX_W),
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (accept_rd),
    .rd_idx   (cpu_idx),
    .wr_en    (st_wr_en),
    .wr_idx   (st_wr_idx),
    .wr_tag   (st_wr_tag),
    .wr_data  (st_wr_data),
    .rd_valid (st_rd_valid),
    .rd_tag   (st_rd_tag),
    .rd_data  (st_rd_data)
  );

  assign lookup_hit  = (state == ST_LOOK) && st_rd_valid && (st_rd_tag == req_tag);
  assign lookup_miss = (state == ST_LOOK) && !lookup_hit;

  assign cpu_ready  = (state == ST_IDLE);
  assign cpu_rvalid = lookup_hit || fill_done;
  assign cpu_rdata  = lookup_hit ? st_rd_data : mem_rdata;
  assign mem_req    = (state == ST_FILL) || (state == ST_WRITE);
  assign mem_we     = (state == ST_WRITE);
  assign mem_addr   = ADDR_W'(dmc_align(64'(req_addr_q)));
  assign mem_wdata  = req_wdata_q;

  AST_WT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_wr |=> mem_req && mem_we && (mem_wdata == $past(cpu_wdata))); // R4
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)); // R4
  AST_READ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    accept_rd |=> (cpu_rvalid || lookup_miss)); // R5
  AST_MISS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_miss |=> mem_req && !mem_we); // R6
  AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready); // R7

endmodule

// File: tb/dm_wordcache_tb_top.sv
module dm_wordcache_tb_top;

  localparam int IW = 6;
  localparam int LN = 1 << IW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready, cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  // reference model: per-line contents and backing memory
  bit          m_valid [LN];
  logic [31:0] m_tag   [LN];
  logic [31:0] m_data  [LN];
  logic [31:0] m_mem   [int unsigned];

  always #5 clk = ~clk;

  dm_wordcache #(.ADDR_W(32), .DATA_W(32), .IDX_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic int lidx(input logic [31:0] a);
    return int'((a / 4) % LN);
  endfunction
  function automatic logic [31:0] ltag(input logic [31:0] a);
    return a / (4 * LN);
  endfunction
  function automatic logic [31:0] memval(input logic [31:0] a);
    int unsigned w = a / 4;
    if (m_mem.exists(w)) return m_mem[w];
    return 32'hA500_0000 ^ (w * 32'h9E37_79B1);
  endfunction

  task automatic idle_check(input string rq);
    chk(rq, "cpu_ready", {31'd0, cpu_ready}, 32'd1);
    chk(rq, "mem_req", {31'd0, mem_req}, 32'd0);
    chk(rq, "cpu_rvalid", {31'd0, cpu_rvalid}, 32'd0);
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d, input int lat);
    int i = lidx(a);
    @(negedge clk);
    chk("R7", "ready before store", {31'd0, cpu_ready}, 32'd1);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
    m_valid[i] = 1'b1; m_tag[i] = ltag(a); m_data[i] = d;
    m_mem[a / 4] = d;
    for (int k = 0; k <= lat; k++) begin
      chk("R4", "mem_req", {31'd0, mem_req}, 32'd1);
      chk("R4", "mem_we", {31'd0, mem_we}, 32'd1);
      chk("R2", "mem_addr", mem_addr, a & ~32'd3);
      chk("R4", "mem_wdata", mem_wdata, d);
      chk("R7", "ready busy", {31'd0, cpu_ready}, 32'd0);
      chk("R4", "rvalid on store", {31'd0, cpu_rvalid}, 32'd0);
      if (k == lat) mem_ack = 1'b1;
      @(negedge clk);
      mem_ack = 1'b0;
    end
    idle_check("R7");
  endtask

  task automatic do_read(input logic [31:0] a, input int lat);
    int i = lidx(a);
    bit hit = m_valid[i] && (m_tag[i] == ltag(a));
    logic [31:0] v;
    @(negedge clk);
    chk("R7", "ready before load", {31'd0, cpu_ready}, 32'd1);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a; cpu_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    cpu_req = 1'b0;
    if (hit) begin
      chk("R5", "hit rvalid", {31'd0, cpu_rvalid}, 32'd1);
      chk("R5", "hit rdata", cpu_rdata, m_data[i]);
      chk("R5", "hit no mem_req", {31'd0, mem_req}, 32'd0);
      @(negedge clk);
      idle_check("R5");
    end else begin
      chk("R6", "lookup rvalid", {31'd0, cpu_rvalid}, 32'd0);
      chk("R6", "lookup mem_req", {31'd0, mem_req}, 32'd0);
      chk("R7", "lookup ready", {31'd0, cpu_ready}, 32'd0);
      @(negedge clk);
      v = memval(a);
      for (int k = 0; k <= lat; k++) begin
        chk("R6", "fill mem_req", {31'd0, mem_req}, 32'd1);
        chk("R6", "fill mem_we", {31'd0, mem_we}, 32'd0);
        chk("R2", "fill mem_addr", mem_addr, a & ~32'd3);
        chk("R7", "fill ready", {31'd0, cpu_ready}, 32'd0);
        if (k == lat) begin
          mem_ack = 1'b1; mem_rdata = v;
          #1;
          chk("R6", "fill rvalid", {31'd0, cpu_rvalid}, 32'd1);
          chk("R6", "fill rdata", cpu_rdata, v);
        end else begin
          chk("R6", "fill early rvalid", {31'd0, cpu_rvalid}, 32'd0);
        end
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = 32'h0BAD_0BAD;
      end
      m_valid[i] = 1'b1; m_tag[i] = ltag(a); m_data[i] = v;
      idle_check("R7");
    end
  endtask

  function automatic logic [31:0] mk(input int tg, input int ix, input int ofs);
    return (32'(tg) * 32'(4 * LN)) + 32'(ix * 4) + 32'(ofs);
  endfunction

  initial begin
    repeat (500000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h1234_5678;
    for (int i = 0; i < LN; i++) begin m_valid[i] = 1'b0; m_tag[i] = '0; m_data[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R1");

    // R1: cold cache misses; R5 hit afterwards, different byte offset (R2)
    do_read(mk(5, 3, 0), 2);
    do_read(mk(5, 3, 2), 0);
    // R3/R4: store with a different tag into the same line, no hit check
    do_write(mk(9, 3, 1), 32'hCAFE_0001, 1);
    do_read(mk(9, 3, 0), 0);      // R3 hit on the stored word
    do_read(mk(5, 3, 3), 3);      // R8 displaced address misses again
    do_read(mk(9, 3, 0), 1);      // R8 now evicted in turn: miss
    // R1: last line and line zero start invalid
    do_read(mk(0, LN - 1, 0), 0);
    do_read(mk(0, 0, 0), 0);
    // store to a cold line then read it back (R3)
    do_write(mk(2, 17, 0), 32'h1111_2222, 0);
    do_read(mk(2, 17, 1), 0);
    // back-to-back stores on one line: last one wins (R3)
    do_write(mk(3, 20, 0), 32'hAAAA_0000, 2);
    do_write(mk(3, 20, 0), 32'hBBBB_0000, 0);
    do_read(mk(3, 20, 0), 0);

    // mixed traffic over a few lines and tags
    for (int n = 0; n < 80; n++) begin
      logic [31:0] a;
      seed = seed * 32'd1103515245 + 32'd12345;
      a = mk(int'((seed >> 8) % 4), int'((seed >> 12) % 6), int'((seed >> 16) % 4));
      if (((seed >> 20) % 3) == 0)
        do_write(a, seed ^ 32'h5A5A_A5A5, int'((seed >> 24) % 4));
      else
        do_read(a, int'((seed >> 26) % 4));
    end

    repeat (2) @(negedge clk);
    idle_check("R7");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule